// File: doc/BRIEF.md
# Ethernet Transmit Frame Serializer

This block turns a frame held in a byte-wide transmit FIFO into the serial bit stream of an IEEE 802.3 frame. It waits until the FIFO holds at least a programmed number of bytes and the channel is open. It then drives, one bit per clock, a preamble, the start delimiter, the frame bytes (destination address through payload), optional zero padding and a 32-bit frame check sequence that it computes itself.

The FIFO is read in first-word-fall-through fashion: `fifo_data` and `fifo_eof` show the head byte, and a one-cycle `fifo_rd` pulse consumes it. The byte flagged by `fifo_eof` closes the frame. Padding is chosen per frame and is captured when the frame starts. Collision handling, retries, flow control and the PHY are left to other blocks.

Top module: `eth_tx_serializer`

## Requirements
- R1: While idle, a frame starts only in a cycle where `fifo_level >= cfg_start_level` and `chan_ok` is 1. `tx_en` goes high on the clock edge that ends that cycle. If either condition is false, `tx_en` stays 0.
- R2: The first 56 bits are seven preamble bytes 0x55 sent least significant bit first, so the line carries 1,0,1,0,… and begins with a 1.
- R3: The preamble is followed by the start delimiter 0xD5, sent as 1,0,1,0,1,0,1,1, and the first FIFO byte follows it directly.
- R4: Frame bytes go out least significant bit first. `fifo_rd` is a one-cycle pulse in the cycle that carries the last bit of the delimiter or of a non-final data byte. `fifo_data` and `fifo_eof` are taken on that edge. Exactly one pulse is given per frame byte.
- R5: The byte with `fifo_eof`=1 is the last byte read for the frame. No further read occurs until a new frame starts.
- R6: With padding enabled, 0x00 bytes follow the data until data plus pad count 60 bytes, so the frame is 64 bytes including the FCS. Longer frames get no pad. `cfg_pad_en` is captured at frame start.
- R7: With padding disabled, a short frame is sent unpadded, with its FCS directly after the last data byte.
- R8: The FCS is the complemented CRC-32 (polynomial 0x04C11DB7, all-ones preset) over the data and pad bytes. It is sent coefficient x^31 first: the bit-reversed register value, least significant bit first.
- R9: `tx_en` is high from the first preamble bit through the last FCS bit, always a whole number of bytes. It is low for at least one cycle between frames. A ready next frame starts after exactly one idle cycle.
- R10: During and right after reset, `tx_en`, `tx_bit` and `fifo_rd` are 0, and `tx_bit` is 0 whenever `tx_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_start_level | input | LVL_W | FIFO fill level needed to start a frame |
| cfg_pad_en | input | 1 | Pad short frames to the minimum size |
| chan_ok | input | 1 | Channel access permitted |
| fifo_level | input | LVL_W | Bytes currently held in the FIFO |
| fifo_data | input | 8 | Head byte of the FIFO |
| fifo_eof | input | 1 | Head byte is the last of its frame |
| fifo_rd | output | 1 | Consume the head byte |
| tx_bit | output | 1 | Serial transmit data |
| tx_en | output | 1 | Transmit enable |

## Verification
Frames of every length from 1 to 70 bytes are sent with padding on and off, and the whole bit stream is compared against one built arithmetically in the bench. The lengths on both sides of 60 bytes separate pad insertion from its absence. Each byte value depends on frame length and position, so a bit-order or CRC error shows in the FCS. The pad setting is flipped mid-frame to show it is captured at start. Gating runs hold the level below the threshold and then drop the channel permit. A back-to-back pair measures the idle gap between frames.

// File: rtl/ethtx_pkg.sv
package ethtx_pkg;

    localparam logic [7:0]  PRE_BYTE = 8'h55;
    localparam logic [7:0]  SFD_BYTE = 8'hD5;
    localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;
    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRE,
        PH_SFD,
        PH_DATA,
        PH_PAD,
        PH_FCS
    } phase_e;

    // One serial CRC step on the bit-reversed register.
    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic b);
        logic [31:0] r;
        r = c >> 1;
        if (c[0] ^ b) r = r ^ CRC_POLY_REFL;
        return r;
    endfunction

endpackage

// File: rtl/ethtx_crc32.sv
module ethtx_crc32
    import ethtx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        adv,
    input  logic        din,
    output logic [31:0] crc_nxt
);

    logic [31:0] crc_q;

    always_comb begin
        crc_nxt = adv ? crc_step(crc_q, din) : crc_q;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) crc_q <= CRC_SEED;
        else            crc_q <= crc_nxt;
    end

endmodule

// File: rtl/ethtx_framer.sv
module ethtx_framer
    import ethtx_pkg::*;
#(
    parameter int LVL_W     = 8,
    parameter int PRE_BYTES = 7,
    parameter int MIN_BODY  = 60
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] cfg_start_level,
    input  logic             cfg_pad_en,
    input  logic             chan_ok,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic [7:0]       fifo_data,
    input  logic             fifo_eof,
    input  logic [31:0]      crc_nxt,
    output logic             fifo_rd,
    output logic             crc_clr,
    output logic             crc_adv,
    output logic             crc_din,
    output logic             tx_bit,
    output logic             tx_en
);

    localparam int PN_W = $clog2(PRE_BYTES + 1);
    localparam int BN_W = $clog2(MIN_BODY + 1);
    localparam logic [PN_W-1:0] PRE_LAST = PN_W'(PRE_BYTES - 1);
    localparam logic [BN_W-1:0] BODY_MIN = BN_W'(MIN_BODY);

    phase_e          ph;
    logic [7:0]      sh;
    logic [2:0]      bit_i;
    logic [PN_W-1:0] pre_n;
    logic [BN_W-1:0] byte_n;
    logic            last_q;
    logic            pad_q;
    logic [31:0]     fcs_sh;
    logic [4:0]      fcs_i;

    logic go, byte_end, body_more;

    always_comb begin
        go        = (fifo_level >= cfg_start_level) && chan_ok;
        byte_end  = (bit_i == 3'd7);
        body_more = pad_q && (byte_n < BODY_MIN);
        fifo_rd   = byte_end && ((ph == PH_SFD) || ((ph == PH_DATA) && !last_q));
        crc_clr   = (ph == PH_IDLE) && go;
        crc_adv   = (ph == PH_DATA) || (ph == PH_PAD);
        crc_din   = sh[0];
        tx_en     = (ph != PH_IDLE);
        case (ph)
            PH_IDLE: tx_bit = 1'b0;
            PH_FCS:  tx_bit = fcs_sh[0];
            default: tx_bit = sh[0];
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph     <= PH_IDLE;
            sh     <= '0;
            bit_i  <= '0;
            pre_n  <= '0;
            byte_n <= '0;
            last_q <= 1'b0;
            pad_q  <= 1'b0;
            fcs_sh <= '0;
            fcs_i  <= '0;
        end else begin
            case (ph)
                PH_IDLE: begin
                    if (go) begin
                        ph     <= PH_PRE;
                        sh     <= PRE_BYTE;
                        bit_i  <= '0;
                        pre_n  <= '0;
                        byte_n <= '0;
                        pad_q  <= cfg_pad_en;
                    end
                end
                PH_FCS: begin
                    fcs_sh <= fcs_sh >> 1;
                    fcs_i  <= fcs_i + 5'd1;
                    if (fcs_i == 5'd31) ph <= PH_IDLE;
                end
                default: begin
                    bit_i <= bit_i + 3'd1;
                    if (!byte_end) begin
                        sh <= sh >> 1;
                    end else begin
                        case (ph)
                            PH_PRE: begin
                                if (pre_n == PRE_LAST) begin
                                    ph <= PH_SFD;
                                    sh <= SFD_BYTE;
                                end else begin
                                    pre_n <= pre_n + 1'b1;
                                    sh    <= PRE_BYTE;
                                end
                            end
                            PH_SFD: begin
                                ph     <= PH_DATA;
                                sh     <= fifo_data;
                                last_q <= fifo_eof;
                                byte_n <= BN_W'(1);
                            end
                            default: begin
                                if ((ph == PH_DATA) && !last_q) begin
                                    sh     <= fifo_data;
                                    last_q <= fifo_eof;
                                    if (byte_n != BODY_MIN) byte_n <= byte_n + 1'b1;
                                end else if (body_more) begin
                                    ph     <= PH_PAD;
                                    sh     <= '0;
                                    byte_n <= byte_n + 1'b1;
                                end else begin
                                    ph     <= PH_FCS;
                                    sh     <= '0;
                                    fcs_sh <= ~crc_nxt;
                                    fcs_i  <= '0;
                                end
                            end
                        endcase
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/eth_tx_serializer.sv
module eth_tx_serializer #(
    parameter int LVL_W     = 8,
    parameter int PRE_BYTES = 7,
    parameter int MIN_BODY  = 60
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] cfg_start_level,
    input  logic             cfg_pad_en,
    input  logic             chan_ok,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic [7:0]       fifo_data,
    input  logic             fifo_eof,
    output logic             fifo_rd,
    output logic             tx_bit,
    output logic             tx_en
);

    logic [31:0] crc_nxt;
    logic        crc_clr, crc_adv, crc_din;

    ethtx_framer #(
        .LVL_W    (LVL_W),
        .PRE_BYTES(PRE_BYTES),
        .MIN_BODY (MIN_BODY)
    ) framer_i (
        .clk            (clk),
        .rst            (rst),
        .cfg_start_level(cfg_start_level),
        .cfg_pad_en     (cfg_pad_en),
        .chan_ok        (chan_ok),
        .fifo_level     (fifo_level),
        .fifo_data      (fifo_data),
        .fifo_eof       (fifo_eof),
        .crc_nxt        (crc_nxt),
        .fifo_rd        (fifo_rd),
        .crc_clr        (crc_clr),
        .crc_adv        (crc_adv),
        .crc_din        (crc_din),
        .tx_bit         (tx_bit),
        .tx_en          (tx_en)
    );

    ethtx_crc32 crc_i (
        .clk    (clk),
        .rst    (rst),
        .clr    (crc_clr),
        .adv    (crc_adv),
        .din    (crc_din),
        .crc_nxt(crc_nxt)
    );

endmodule

// File: rtl/eth_tx_serializer_chk.sv
module eth_tx_serializer_chk #(
    parameter int LVL_W     = 8,
    parameter int PRE_BYTES = 7
) (
    input logic             clk,
    input logic             rst,
    input logic [LVL_W-1:0] cfg_start_level,
    input logic             chan_ok,
    input logic [LVL_W-1:0] fifo_level,
    input logic             fifo_rd,
    input logic             tx_bit,
    input logic             tx_en
);

    localparam int MIN_BITS = 8 * (PRE_BYTES + 1) + 8 + 32;

    logic [15:0] run_q;

    always_ff @(posedge clk) begin
        if (rst)                run_q <= '0;
        else if (!tx_en)        run_q <= '0;
        else if (run_q != '1)   run_q <= run_q + 16'd1;
    end

    AST_START_GATED: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_en) |-> $past((fifo_level >= cfg_start_level) && chan_ok)); // R1

    AST_FIRST_BIT_ONE: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_en) |-> tx_bit); // R2

    AST_READ_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        fifo_rd |-> tx_en); // R4

    AST_READ_SPACED: assert property (@(posedge clk) disable iff (rst)
        fifo_rd |=> !fifo_rd); // R4

    AST_WHOLE_BYTES: assert property (@(posedge clk) disable iff (rst)
        (!tx_en && run_q != 16'd0) |-> (run_q[2:0] == 3'd0 && run_q >= 16'(MIN_BITS))); // R9

    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
        !tx_en |-> !tx_bit); // R10

endmodule

bind eth_tx_serializer eth_tx_serializer_chk #(
    .LVL_W    (LVL_W),
    .PRE_BYTES(PRE_BYTES)
) chk_i (
    .clk            (clk),
    .rst            (rst),
    .cfg_start_level(cfg_start_level),
    .chan_ok        (chan_ok),
    .fifo_level     (fifo_level),
    .fifo_rd        (fifo_rd),
    .tx_bit         (tx_bit),
    .tx_en          (tx_en)
);

// File: tb/eth_tx_serializer_tb_top.sv
module eth_tx_serializer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int LVL_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [LVL_W-1:0] cfg_start_level = '0;
    logic             cfg_pad_en = 1'b0;
    logic             chan_ok = 1'b0;
    logic [LVL_W-1:0] fifo_level;
    logic [7:0]       fifo_data;
    logic             fifo_eof;
    logic             fifo_rd;
    logic             tx_bit;
    logic             tx_en;

    int checks = 0;
    int fails  = 0;

    logic [7:0] mem [0:511];
    logic       eofm[0:511];
    int wp = 0;
    int rd_ptr = 0;

    logic got[0:2047];
    logic exp_b[0:2047];

    always #(CLK_PERIOD/2) clk = ~clk;

    eth_tx_serializer dut_i (
        .clk(clk), .rst(rst), .cfg_start_level(cfg_start_level),
        .cfg_pad_en(cfg_pad_en), .chan_ok(chan_ok), .fifo_level(fifo_level),
        .fifo_data(fifo_data), .fifo_eof(fifo_eof), .fifo_rd(fifo_rd),
        .tx_bit(tx_bit), .tx_en(tx_en)
    );

    always_comb begin
        fifo_level = ((wp - rd_ptr) > 255) ? 8'd255 : 8'(wp - rd_ptr);
        fifo_data  = mem[rd_ptr % 512];
        fifo_eof   = eofm[rd_ptr % 512];
    end

    always @(posedge clk) if (fifo_rd) rd_ptr <= rd_ptr + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c ^ {24'h0, d};
        for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
        return r;
    endfunction

    function automatic logic [7:0] pat(input int len, input int i);
        return 8'((len * 7 + i * 13 + 5) ^ (i << 3));
    endfunction

    task automatic load(input int len);
        for (int i = 0; i < len; i++) begin
            mem[(wp + i) % 512]  = pat(len, i);
            eofm[(wp + i) % 512] = (i == len - 1);
        end
        wp = wp + len;
    endtask

    task automatic seg(input int from, input int to, input string req, input string what);
        int bad = 0;
        for (int i = from; i < to; i++) if (got[i] !== exp_b[i]) bad++;
        check(bad == 0, req, what, bad, 0);
    endtask

    task automatic run_frame(input int len, input bit pad);
        int lat, nb, rds, body, n;
        logic [31:0] crc;
        logic [7:0] b;
        @(negedge clk);
        cfg_pad_en = pad;
        cfg_start_level = (len > 8) ? 8'd8 : 8'(len);
        load(len);
        chan_ok = 1'b1;
        lat = 0;
        do begin @(negedge clk); lat++; end while (!tx_en && lat < 20);
        check(lat == 1, "R1", "start latency", lat, 1);
        chan_ok = 1'b0;
        cfg_pad_en = !pad;
        nb = 0; rds = 0;
        while (tx_en && nb < 2048) begin
            got[nb] = tx_bit;
            if (fifo_rd) rds++;
            nb++;
            @(negedge clk);
        end
        body = (pad && len < 60) ? 60 : len;
        n = 0;
        for (int i = 0; i < 56; i++) exp_b[n++] = (i % 2 == 0);
        for (int i = 0; i < 8; i++) exp_b[n++] = (i % 2 == 0) || (i == 7);
        crc = 32'hFFFFFFFF;
        for (int j = 0; j < body; j++) begin
            b = (j < len) ? pat(len, j) : 8'h00;
            crc = crc_byte(crc, b);
            for (int k = 0; k < 8; k++) exp_b[n++] = b[k];
        end
        crc = ~crc;
        for (int k = 0; k < 32; k++) exp_b[n++] = crc[k];
        check(nb == n, pad ? "R6" : "R7", "frame bit count", nb, n);
        if (nb == n) begin
            seg(0, 56, "R2", "preamble bits");
            seg(56, 64, "R3", "delimiter bits");
            seg(64, 64 + 8 * len, "R4", "data bits");
            seg(64 + 8 * len, 64 + 8 * body, pad ? "R6" : "R7", "pad bits");
            seg(64 + 8 * body, n, "R8", "fcs bits");
        end
        check(rds == len, "R4", "read pulses", rds, len);
        check(rd_ptr == wp, "R5", "bytes consumed", rd_ptr, wp);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int cnt;
        bit seen;
        for (int i = 0; i < 512; i++) begin mem[i] = 8'h00; eofm[i] = 1'b0; end
        repeat (3) @(negedge clk);
        check(!tx_en && !tx_bit && !fifo_rd, "R10", "outputs in reset",
              {tx_en, tx_bit, fifo_rd}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!tx_en && !tx_bit && !fifo_rd, "R10", "outputs after reset",
              {tx_en, tx_bit, fifo_rd}, 0);

        for (int len = 1; len <= 70; len++) begin
            run_frame(len, 1'b0);
            run_frame(len, 1'b1);
        end

        // R1 gating: level below threshold, then permit withheld
        @(negedge clk);
        cfg_pad_en = 1'b0;
        cfg_start_level = 8'd12;
        load(10);
        chan_ok = 1'b1;
        seen = 0;
        repeat (30) begin @(negedge clk); if (tx_en) seen = 1; end
        check(!seen, "R1", "start below threshold", seen, 0);
        chan_ok = 1'b0;
        cfg_start_level = 8'd10;
        seen = 0;
        repeat (30) begin @(negedge clk); if (tx_en) seen = 1; end
        check(!seen, "R1", "start without permit", seen, 0);
        chan_ok = 1'b1;
        @(negedge clk);
        check(tx_en, "R1", "start once permitted", tx_en, 1);
        chan_ok = 1'b0;
        cnt = 0;
        while (tx_en && cnt < 4000) begin cnt++; @(negedge clk); end
        check(cnt == 64 + 80 + 32, "R7", "gated frame length", cnt, 176);

        // R9 back-to-back: two 5-byte frames queued
        cfg_start_level = 8'd1;
        load(5);
        load(5);
        chan_ok = 1'b1;
        cnt = 0;
        do begin @(negedge clk); cnt++; end while (!tx_en && cnt < 20);
        cnt = 0;
        while (tx_en && cnt < 4000) begin cnt++; @(negedge clk); end
        check(cnt == 136, "R9", "first frame length", cnt, 136);
        @(negedge clk);
        check(tx_en, "R9", "one idle cycle between frames", tx_en, 1);
        chan_ok = 1'b0;
        cnt = 1;
        @(negedge clk);
        while (tx_en && cnt < 4000) begin cnt++; @(negedge clk); end
        check(cnt == 136, "R9", "second frame length", cnt, 136);
        check(rd_ptr == wp, "R5", "both frames consumed", rd_ptr, wp);
        repeat (20) @(negedge clk);
        check(!tx_en && !tx_bit, "R10", "idle after frames", {tx_en, tx_bit}, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule